// File: doc/BRIEF.md
# Graphics Address Remapping Table

This block remaps I/O virtual addresses that fall inside one fixed aperture onto physical page frames through a single-level table. Each 4 KiB page of the aperture has one entry holding a valid flag and a frame address. Software reaches the table only through two registers used as an address/data pair. It first places the byte address of an aperture page in the entry address register. It then writes the entry data register to store an entry, or reads it to fetch the stored entry. A control register holds the global translation enable.

A requester presents an address on the translation port for one cycle. One cycle later the block returns the physical address: the entry's frame bits joined to the page offset. It returns a fault instead when translation is off, when the address lies outside the aperture, or when the entry's valid flag is clear. The aperture base and page count are parameters. The default is 1024 pages at base 0x4000_0000, which gives a 4 MiB window.

Two small state machines sequence the two ports. The register port machine has two states. RP_IDLE moves to RP_RESP on a register read. RP_RESP stays in RP_RESP when another read follows and returns to RP_IDLE otherwise. The lookup machine has two states. LK_IDLE moves to LK_DONE on a translation request. LK_DONE stays in LK_DONE on a back-to-back request and returns to LK_IDLE otherwise. Read data is valid while the register machine is in RP_RESP, and a translation result is valid while the lookup machine is in LK_DONE.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, reg_rvalid and xl_ack are low, and every table entry reads back as zero.
- R2: The control register sits at offset 0x24 and keeps only bit 0 of a write. Bit 0 = 1 enables translation and 0 disables it. A read returns the current value in bit 0 with bits 31:1 zero.
- R3: The entry address register sits at offset 0x28. It holds all 32 bits written to it, and a read returns them unchanged.
- R4: A write to offset 0x2c stores write-data bits 31:12 in the entry whose index is (entry address − base) >> 12. Bits 11:0 of the entry address play no part in the selection. A read of offset 0x2c returns the stored entry, with bits 11:0 zero.
- R5: When the entry address lies outside the aperture, writes to 0x2c leave every entry unchanged and reads of 0x2c return zero.
- R6: A register read returns its data with reg_rvalid high exactly one cycle after reg_rd. reg_rvalid is low in the cycle after a write. Offsets other than 0x24, 0x28 and 0x2c read as zero, and writes to them change nothing.
- R7: xl_ack is high exactly one cycle after xl_req. When the request does not fault, xl_paddr = {1'b0, entry bits 30:12, xl_vaddr bits 11:0}.
- R8: A request made while translation is disabled faults.
- R9: A request faults when xl_vaddr is below the base or above base + PAGE_COUNT*4096 − 1. Both boundary bytes themselves are accepted.
- R10: A request faults when bit 31 of the entry (the valid flag) is clear, which includes an all-zero, unmapped entry. On any fault xl_paddr is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| reg_rdata | output | 32 | Register read data |
| xl_req | input | 1 | Translation request |
| xl_vaddr | input | 32 | I/O virtual address to translate |
| xl_ack | output | 1 | Translation result valid, one cycle after xl_req |
| xl_paddr | output | 32 | Translated physical address, zero on fault |
| xl_fault | output | 1 | Translation fault |

## Verification
Both ports answer exactly one clock after their strobe. Register read data with reg_rvalid, and the translated address with xl_ack and xl_fault, are due at the first rising edge after the strobed cycle. The bench raises each strobe just after a falling edge and drops it at the next falling edge. It samples the response at that same falling edge, half a cycle after the registering edge, so each check reads exactly the one-cycle result. Table writes land at the edge that ends the write strobe, so a lookup or read-back of that entry is issued no earlier than the following cycle.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int unsigned PG_SHIFT = 12;
    localparam int unsigned ENT_W    = 32 - PG_SHIFT;

    localparam logic [7:0] OFS_CTRL  = 8'h24;
    localparam logic [7:0] OFS_EADDR = 8'h28;
    localparam logic [7:0] OFS_EDATA = 8'h2C;

    typedef enum logic [1:0] {
        DEC_NONE,
        DEC_CTRL,
        DEC_EADDR,
        DEC_EDATA
    } reg_sel_e;

    typedef enum logic [0:0] {
        RP_IDLE,
        RP_RESP
    } rport_state_e;

    typedef enum logic [0:0] {
        LK_IDLE,
        LK_DONE
    } lookup_state_e;

    // True when byte address a lies in [base, base + span - 1]
    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [32:0] span);
        logic [32:0] off;
        off = {1'b0, a} - {1'b0, base};
        return (a >= base) && (off < span);
    endfunction

endpackage

// File: rtl/remap_table.sv
module remap_table #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned ENT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [ENT_W-1:0] rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [ENT_W-1:0] rdata_b
);

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (we && (32'(widx) < DEPTH)) begin
            mem[widx] <= wdata;
        end
    end

    always_comb begin
        rdata_a = (32'(ridx_a) < DEPTH) ? mem[ridx_a] : '0;
        rdata_b = (32'(ridx_b) < DEPTH) ? mem[ridx_b] : '0;
    end

endmodule

// File: rtl/remap_regs.sv
module remap_regs
    import remap_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter int unsigned PAGE_COUNT = 1024,
    parameter int unsigned IDX_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             reg_rvalid,
    output logic [31:0]      reg_rdata,
    output logic             ctrl_en,
    output logic             tbl_we,
    output logic [IDX_W-1:0] tbl_idx,
    output logic [ENT_W-1:0] tbl_wdata,
    input  logic [ENT_W-1:0] tbl_rdata
);

    localparam logic [32:0] SPAN = 33'(PAGE_COUNT) << PG_SHIFT;

    reg_sel_e     sel;
    rport_state_e state_q, state_d;
    logic         en_q;
    logic [31:0]  eaddr_q;
    logic [31:0]  eoff;
    logic         e_hit;
    logic [31:0]  rd_mux;
    logic [31:0]  rdata_q;

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL:  sel = DEC_CTRL;
            OFS_EADDR: sel = DEC_EADDR;
            OFS_EDATA: sel = DEC_EDATA;
            default:   sel = DEC_NONE;
        endcase
    end

    always_comb begin
        eoff      = eaddr_q - BASE_ADDR;
        e_hit     = in_window(eaddr_q, BASE_ADDR, SPAN);
        tbl_idx   = e_hit ? IDX_W'(eoff >> PG_SHIFT) : '0;
        tbl_we    = reg_wr && (sel == DEC_EDATA) && e_hit;
        tbl_wdata = reg_wdata[31:PG_SHIFT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            eaddr_q <= '0;
        end else if (reg_wr) begin
            if (sel == DEC_CTRL)  en_q    <= reg_wdata[0];
            if (sel == DEC_EADDR) eaddr_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            DEC_CTRL:  rd_mux = {31'b0, en_q};
            DEC_EADDR: rd_mux = eaddr_q;
            DEC_EDATA: rd_mux = e_hit ? {tbl_rdata, {PG_SHIFT{1'b0}}} : '0;
            default:   rd_mux = '0;
        endcase
    end

    // Next-state logic for the read-response machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (reg_rd) state_d = RP_RESP;
            RP_RESP: state_d = reg_rd ? RP_RESP : RP_IDLE;
            default: state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (reg_rd) rdata_q <= rd_mux;
        end
    end

    // Outputs of the read-response machine
    always_comb begin
        reg_rvalid = (state_q == RP_RESP);
        reg_rdata  = rdata_q;
        ctrl_en    = en_q;
    end

endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
    import remap_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter int unsigned PAGE_COUNT = 1024,
    parameter int unsigned IDX_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xl_req,
    input  logic [31:0]      xl_vaddr,
    input  logic             ctrl_en,
    output logic [IDX_W-1:0] lk_idx,
    input  logic [ENT_W-1:0] lk_ent,
    output logic             xl_ack,
    output logic [31:0]      xl_paddr,
    output logic             xl_fault
);

    localparam logic [32:0] SPAN = 33'(PAGE_COUNT) << PG_SHIFT;

    lookup_state_e state_q, state_d;
    logic [31:0]   voff;
    logic          v_hit;
    logic          fault_d;
    logic [31:0]   pa_d;
    logic [31:0]   pa_q;
    logic          fault_q;

    always_comb begin
        voff    = xl_vaddr - BASE_ADDR;
        v_hit   = in_window(xl_vaddr, BASE_ADDR, SPAN);
        lk_idx  = v_hit ? IDX_W'(voff >> PG_SHIFT) : '0;
        fault_d = !ctrl_en || !v_hit || !lk_ent[ENT_W-1];
        pa_d    = fault_d ? 32'b0
                          : {1'b0, lk_ent[ENT_W-2:0], xl_vaddr[PG_SHIFT-1:0]};
    end

    // Next-state logic for the lookup machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: if (xl_req) state_d = LK_DONE;
            LK_DONE: state_d = xl_req ? LK_DONE : LK_IDLE;
            default: state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (xl_req) begin
                pa_q    <= pa_d;
                fault_q <= fault_d;
            end
        end
    end

    // Outputs of the lookup machine
    always_comb begin
        xl_ack   = (state_q == LK_DONE);
        xl_paddr = pa_q;
        xl_fault = fault_q;
    end

endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import remap_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter int unsigned PAGE_COUNT = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        reg_rvalid,
    output logic [31:0] reg_rdata,
    input  logic        xl_req,
    input  logic [31:0] xl_vaddr,
    output logic        xl_ack,
    output logic [31:0] xl_paddr,
    output logic        xl_fault
);

    localparam int unsigned IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

    logic             ctrl_en;
    logic             tbl_we;
    logic [IDX_W-1:0] tbl_idx;
    logic [ENT_W-1:0] tbl_wdata;
    logic [ENT_W-1:0] tbl_rdata;
    logic [IDX_W-1:0] lk_idx;
    logic [ENT_W-1:0] lk_ent;

    remap_regs #(
        .BASE_ADDR (BASE_ADDR),
        .PAGE_COUNT(PAGE_COUNT),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rvalid(reg_rvalid),
        .reg_rdata (reg_rdata),
        .ctrl_en   (ctrl_en),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx),
        .tbl_wdata (tbl_wdata),
        .tbl_rdata (tbl_rdata)
    );

    remap_table #(
        .DEPTH(PAGE_COUNT),
        .IDX_W(IDX_W),
        .ENT_W(ENT_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .widx   (tbl_idx),
        .wdata  (tbl_wdata),
        .ridx_a (tbl_idx),
        .rdata_a(tbl_rdata),
        .ridx_b (lk_idx),
        .rdata_b(lk_ent)
    );

    remap_xlate #(
        .BASE_ADDR (BASE_ADDR),
        .PAGE_COUNT(PAGE_COUNT),
        .IDX_W     (IDX_W)
    ) u_xlate (
        .clk     (clk),
        .rst_n   (rst_n),
        .xl_req  (xl_req),
        .xl_vaddr(xl_vaddr),
        .ctrl_en (ctrl_en),
        .lk_idx  (lk_idx),
        .lk_ent  (lk_ent),
        .xl_ack  (xl_ack),
        .xl_paddr(xl_paddr),
        .xl_fault(xl_fault)
    );

endmodule

// File: rtl/remap_checker.sv
module remap_checker
    import remap_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
    parameter int unsigned PAGE_COUNT = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [7:0]  reg_addr,
    input logic        wdata_b0,
    input logic        reg_rvalid,
    input logic        xl_req,
    input logic [31:0] xl_vaddr,
    input logic        xl_ack,
    input logic [31:0] xl_paddr,
    input logic        xl_fault,
    input logic        ctrl_en
);

    localparam logic [32:0] SPAN = 33'(PAGE_COUNT) << PG_SHIFT;

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R6

    AST_NO_RVALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid); // R6

    AST_CTRL_TAKES_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTRL) |=> (ctrl_en == $past(wdata_b0))); // R2

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> xl_ack); // R7

    AST_OFFSET_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> (xl_fault || xl_paddr[11:0] == $past(xl_vaddr[11:0]))); // R7

    AST_FAULT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !ctrl_en) |=> xl_fault); // R8

    AST_FAULT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !in_window(xl_vaddr, BASE_ADDR, SPAN)) |=> xl_fault); // R9

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_ack && xl_fault) |-> (xl_paddr == 32'b0)); // R10

endmodule

bind aperture_remap remap_checker #(
    .BASE_ADDR (BASE_ADDR),
    .PAGE_COUNT(PAGE_COUNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .wdata_b0  (reg_wdata[0]),
    .reg_rvalid(reg_rvalid),
    .xl_req    (xl_req),
    .xl_vaddr  (xl_vaddr),
    .xl_ack    (xl_ack),
    .xl_paddr  (xl_paddr),
    .xl_fault  (xl_fault),
    .ctrl_en   (ctrl_en)
);

// File: tb/aperture_remap_test.sv
`timescale 1ns/1ps
module aperture_remap_test;

    localparam logic [31:0] B    = 32'h4000_0000;
    localparam logic [31:0] PG   = 32'h0000_1000;
    localparam logic [7:0]  CTRL = 8'h24;
    localparam logic [7:0]  EADR = 8'h28;
    localparam logic [7:0]  EDAT = 8'h2C;
    localparam int          NV   = 8;

    // {vaddr, expected fault, expected paddr}
    localparam logic [64:0] XV [NV] = '{
        {B + 32'h0123,              1'b0, 32'h0001_2123},
        {B + 5*PG + 32'hFFF,        1'b0, 32'h0ABC_DFFF},
        {B + 1023*PG + 32'hFFF,     1'b0, 32'h7FFF_FFFF},
        {B + 1024*PG,               1'b1, 32'h0},
        {B - 32'h1,                 1'b1, 32'h0},
        {B + 7*PG + 32'h4,          1'b1, 32'h0},
        {B + 9*PG,                  1'b1, 32'h0},
        {B + 32'hFFF,               1'b0, 32'h0001_2FFF}
    };
    localparam string XTAG [NV] = '{"R7", "R7", "R9", "R9", "R9", "R10", "R10", "R7"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [31:0] reg_rdata;
    logic        xl_req = 1'b0;
    logic [31:0] xl_vaddr = '0;
    logic        xl_ack;
    logic [31:0] xl_paddr;
    logic        xl_fault;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    aperture_remap uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rvalid(reg_rvalid),
        .reg_rdata (reg_rdata),
        .xl_req    (xl_req),
        .xl_vaddr  (xl_vaddr),
        .xl_ack    (xl_ack),
        .xl_paddr  (xl_paddr),
        .xl_fault  (xl_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R6 rvalid", {31'b0, reg_rvalid}, 32'h1);
        d = reg_rdata;
    endtask

    task automatic xlate(input logic [31:0] va, output logic f, output logic [31:0] pa);
        @(negedge clk);
        xl_req = 1'b1; xl_vaddr = va;
        @(negedge clk);
        xl_req = 1'b0;
        chk("R7 ack", {31'b0, xl_ack}, 32'h1);
        f  = xl_fault;
        pa = xl_paddr;
    endtask

    task automatic set_entry(input logic [31:0] a, input logic [31:0] d);
        reg_write(EADR, a);
        reg_write(EDAT, d);
    endtask

    initial begin
        logic [31:0] rd;
        logic        f;
        logic [31:0] pa;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack", {31'b0, xl_ack}, 32'h0);
        chk("R1 rvalid", {31'b0, reg_rvalid}, 32'h0);
        reg_read(CTRL, rd);
        chk("R1 ctrl", rd, 32'h0);
        reg_write(EADR, B + 5*PG);
        reg_read(EDAT, rd);
        chk("R1 entry", rd, 32'h0);
        reg_write(EADR, B + 1023*PG);
        reg_read(EDAT, rd);
        chk("R1 last entry", rd, 32'h0);

        set_entry(B,           32'h8001_2000);
        set_entry(B + 5*PG,    32'h8ABC_D000);
        set_entry(B + 1023*PG, 32'hFFFF_F000);
        set_entry(B + 7*PG,    32'h0123_4000);
        set_entry(B + 9*PG,    32'h0000_0000);

        xlate(B + 32'h123, f, pa);
        chk("R8 fault off", {31'b0, f}, 32'h1);
        chk("R10 pa zero", pa, 32'h0);

        reg_write(CTRL, 32'h1);
        chk("R6 no rvalid after write", {31'b0, reg_rvalid}, 32'h0);
        reg_read(CTRL, rd);
        chk("R2 enable", rd, 32'h1);

        for (int i = 0; i < NV; i++) begin
            xlate(XV[i][64:33], f, pa);
            chk({XTAG[i], " fault"}, {31'b0, f}, {31'b0, XV[i][32]});
            chk({XTAG[i], " paddr"}, pa, XV[i][31:0]);
        end

        reg_write(EADR, 32'h1234_5678);
        reg_read(EADR, rd);
        chk("R3 eaddr", rd, 32'h1234_5678);

        set_entry(B + 2*PG, 32'h8ABC_DFFF);
        reg_read(EDAT, rd);
        chk("R4 low bits dropped", rd, 32'h8ABC_D000);
        reg_write(EADR, B + 5*PG + 32'h7FF);
        reg_read(EDAT, rd);
        chk("R4 offset ignored", rd, 32'h8ABC_D000);

        set_entry(B + 1024*PG, 32'hFFFF_F000);
        reg_read(EDAT, rd);
        chk("R5 read outside", rd, 32'h0);
        reg_write(EADR, B);
        reg_read(EDAT, rd);
        chk("R5 no alias write", rd, 32'h8001_2000);
        set_entry(B - PG, 32'hFFFF_F000);
        reg_read(EDAT, rd);
        chk("R5 below base", rd, 32'h0);
        xlate(B + 32'h10, f, pa);
        chk("R5 entry 0 kept", pa, 32'h0001_2010);

        reg_read(8'h30, rd);
        chk("R6 unmapped read", rd, 32'h0);

        reg_write(CTRL, 32'h3);
        reg_read(CTRL, rd);
        chk("R2 bit0 only", rd, 32'h1);
        reg_write(CTRL, 32'h0);
        reg_read(CTRL, rd);
        chk("R2 disable", rd, 32'h0);
        reg_write(8'h20, 32'h1);
        reg_read(CTRL, rd);
        chk("R6 unmapped write", rd, 32'h0);
        xlate(B + 32'h123, f, pa);
        chk("R8 fault after disable", {31'b0, f}, 32'h1);
        chk("R10 pa zero off", pa, 32'h0);

        @(negedge clk);
        chk("R7 ack drops", {31'b0, xl_ack}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule